// File: doc/BRIEF.md
# Multiply-Accumulate Datapath with Accumulator Saturation

This block multiplies two 32-bit operands, adjusts the 64-bit product according to the active arithmetic mode, adds it to one of four accumulators, and can then saturate that accumulator. Three modes exist: signed integer, unsigned integer and fractional. A mode/status word holds the saturate-on-overflow enable, the round enable, the signed/unsigned select, the fractional/integer select, a sticky overflow flag and one overflow flag per accumulator. The same word comes out on `status` after every command.

Each command is taken with a valid/ready handshake and walks a small state machine. States: `ST_IDLE` (ready, waiting), `ST_MUL` (adjusted product is registered), `ST_ACC` (product is added to the chosen accumulator), `ST_SAT` (chosen accumulator is saturated), `ST_XFER` (move, load or status write) and `ST_DONE` (result presented for one cycle). Transitions: IDLE→MUL on an accepted multiply-accumulate; IDLE→SAT on an accepted saturate; IDLE→XFER on any other accepted command; MUL→ACC always; ACC→SAT when the command asked for saturation, else ACC→DONE; SAT→DONE; XFER→DONE; DONE→IDLE. Each accumulator is stored 64 bits wide so that saturation can see bits above the nominal 48-bit range.

Top module: `mac_sat_unit`

## Requirements
- R1: Signed-integer mode (status bit 6 = 0, bit 7 = 1): the product is the signed 64-bit product. If it differs from its own low 40 bits sign-extended, the overflow flag (bit 4) is set. With saturate enable (bit 8) set, such a product is replaced by 2^50 when non-negative and by the bitwise inverse of 2^50 when negative.
- R2: Unsigned-integer mode (bit 6 = 0, bit 7 = 0): the product is unsigned. Any set bit among product bits 63..40 sets the overflow flag. Such a product then becomes 2^50 with saturate enable set, or keeps only its low 40 bits without it.
- R3: Fractional mode (bit 6 = 1): the signed product is shifted right arithmetically by 24. With round enable (bit 5) set, a discarded 24-bit remainder above 0x800000 adds one, and a remainder of exactly 0x800000 adds the shifted value's bit 0.
- R4: Command code 0 (multiply-accumulate) adds the adjusted product, modulo 2^64, to the accumulator selected by `in_dst` and leaves the other accumulators unchanged; `res_prod` shows the adjusted product.
- R5: Signed saturation (command 1, or command 0 with `in_sat`, in signed-integer mode): a value that differs from its low 48 bits sign-extended sets the overflow flag. The accumulator takes the sign-extended value, except that with the overflow flag and saturate enable both set it is clamped to 0x7FFFFFFF when that value is non-negative and to the 64-bit inverse of 0x7FFFFFFF when it is negative. Whenever the overflow flag is set after the check, the accumulator's own flag (status bit `in_dst`) is set.
- R6: Unsigned saturation: any set bit among 63..48 sets the overflow flag. When the flag is set, saturate enable gives 0 for a value above 2^53 and 2^48−1 otherwise; without saturate enable the value is cut to 48 bits. The per-accumulator flag rule of R5 applies.
- R7: Fractional saturation: detection as in R5. With the overflow flag and saturate enable set, the value clamps to 0x7FFFFFFFFFFF or its 64-bit inverse, chosen by the sign of the sign-extended value. The per-accumulator flag rule of R5 applies.
- R8: Command code 2 copies the accumulator `in_src` into accumulator `in_dst` and copies per-accumulator flag `in_src` to flag `in_dst`.
- R9: The overflow flag is sticky: only command code 4, which writes `in_a[8:0]` into the status word, can clear it.
- R10: `in_ready` is high only in the idle state, so it drops the cycle after a command is taken. `res_valid` is high for exactly one cycle per command, and `res_acc` then shows accumulator `in_dst`.
- R11: After reset all accumulators and the status word are zero, `in_ready` is high and `res_valid` is low.
- R12: Command code 3 loads accumulator `in_dst` with `{in_a, in_b}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Block idle and able to take a command |
| in_op | input | 3 | Command code: 0 mac, 1 saturate, 2 move, 3 load, 4 status write |
| in_dst | input | 2 | Target accumulator |
| in_src | input | 2 | Source accumulator for a move |
| in_sat | input | 1 | Saturate the target after a multiply-accumulate |
| in_a | input | 32 | First operand, high load word, or new status word |
| in_b | input | 32 | Second operand or low load word |
| res_valid | output | 1 | One-cycle result strobe |
| res_prod | output | 64 | Adjusted product of the last multiply |
| res_acc | output | 64 | Target accumulator after the command |
| status | output | 9 | {sat enable, signed, fractional, round, overflow, per-accumulator flags[3:0]} |

## Verification
The bench builds the block with its default parameters: 32-bit operands, a 40-bit integer product window, a 24-bit fractional shift, the 48-bit saturation boundary, 2^50 as the forced product and 2^53 as the unsigned clamp threshold. With these values a single full-range product crosses the 40-bit window, and loaded accumulator values land on either side of the 48-bit and 2^53 limits. Fractional operands of 2^23 times small factors hit the exact round-half case with both parities of the shifted value. Random commands, status words and operands then mix the modes, the sticky flag and the per-accumulator flags over long command runs.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int unsigned NACC  = 4;
    localparam int unsigned SEL_W = $clog2(NACC);

    // Mode and status word: saturate enable, signed, fractional, round,
    // sticky overflow, per-accumulator overflow flags.
    typedef struct packed {
        logic            omc;
        logic            su;
        logic            fi;
        logic            rt;
        logic            v;
        logic [NACC-1:0] pav;
    } mac_sr_t;

    localparam int unsigned SR_W = $bits(mac_sr_t);

    typedef enum logic [2:0] {
        OP_MAC  = 3'd0,
        OP_SAT  = 3'd1,
        OP_MOVE = 3'd2,
        OP_LOAD = 3'd3,
        OP_WRSR = 3'd4
    } mac_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_ACC,
        ST_SAT,
        ST_XFER,
        ST_DONE
    } mac_state_e;

    typedef enum logic [1:0] {
        MD_UINT,
        MD_SINT,
        MD_FRAC
    } mac_mode_e;

    function automatic mac_mode_e mode_of(mac_sr_t s);
        if (s.fi)      return MD_FRAC;
        else if (s.su) return MD_SINT;
        else           return MD_UINT;
    endfunction

endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
#(
    parameter int OP_W      = 32,
    parameter int KEEP_W    = 40,
    parameter int FRAC_SH   = 24,
    parameter int FORCE_BIT = 50
) (
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    input  mac_mode_e         mode,
    input  logic              omc,
    input  logic              rt,
    output logic [2*OP_W-1:0] prod,
    output logic              ovf
);

    localparam int WIDE = 2 * OP_W;
    localparam logic [WIDE-1:0]    FORCE_VAL = WIDE'(1) << FORCE_BIT;
    localparam logic [WIDE-1:0]    KEEP_MASK = (WIDE'(1) << KEEP_W) - WIDE'(1);
    localparam logic [FRAC_SH-1:0] HALF      = FRAC_SH'(1) << (FRAC_SH - 1);

    logic signed [WIDE-1:0] s_full;
    logic        [WIDE-1:0] u_full;
    logic        [WIDE-1:0] s_sext;
    logic signed [WIDE-1:0] f_shift;
    logic [FRAC_SH-1:0]     f_rem;
    logic                   f_up;

    always_comb begin
        s_full  = $signed({{OP_W{a[OP_W-1]}}, a}) * $signed({{OP_W{b[OP_W-1]}}, b});
        u_full  = {{OP_W{1'b0}}, a} * {{OP_W{1'b0}}, b};
        s_sext  = {{(WIDE-KEEP_W){s_full[KEEP_W-1]}}, s_full[KEEP_W-1:0]};
        f_shift = s_full >>> FRAC_SH;
        f_rem   = s_full[FRAC_SH-1:0];
        f_up    = rt && ((f_rem > HALF) || ((f_rem == HALF) && f_shift[0]));

        prod = '0;
        ovf  = 1'b0;
        unique case (mode)
            MD_SINT: begin
                ovf  = (s_sext != s_full);
                prod = s_full;
                if (ovf && omc)
                    prod = s_full[WIDE-1] ? ~FORCE_VAL : FORCE_VAL;
            end
            MD_UINT: begin
                ovf  = |u_full[WIDE-1:KEEP_W];
                prod = u_full;
                if (ovf)
                    prod = omc ? FORCE_VAL : (u_full & KEEP_MASK);
            end
            MD_FRAC: begin
                prod = f_shift + WIDE'(f_up);
            end
            default: begin
                prod = '0;
            end
        endcase
    end

endmodule

// File: rtl/mac_saturate.sv
module mac_saturate
    import mac_pkg::*;
#(
    parameter int WIDE     = 64,
    parameter int ACC_W    = 48,
    parameter int SINT_W   = 32,
    parameter int UBIG_BIT = 53
) (
    input  logic [WIDE-1:0] val,
    input  mac_mode_e       mode,
    input  logic            omc,
    input  logic            v_in,
    output logic [WIDE-1:0] res,
    output logic            ovf
);

    localparam logic [WIDE-1:0] SMAX = (WIDE'(1) << (SINT_W - 1)) - WIDE'(1);
    localparam logic [WIDE-1:0] FMAX = (WIDE'(1) << (ACC_W - 1)) - WIDE'(1);
    localparam logic [WIDE-1:0] UMAX = (WIDE'(1) << ACC_W) - WIDE'(1);
    localparam logic [WIDE-1:0] UBIG = WIDE'(1) << UBIG_BIT;

    logic [WIDE-1:0] sext;
    logic            flag;

    always_comb begin
        sext = {{(WIDE-ACC_W){val[ACC_W-1]}}, val[ACC_W-1:0]};
        res  = val;
        ovf  = 1'b0;
        flag = 1'b0;
        unique case (mode)
            MD_SINT: begin
                ovf  = (sext != val);
                flag = ovf || v_in;
                res  = sext;
                if (flag && omc)
                    res = sext[WIDE-1] ? ~SMAX : SMAX;
            end
            MD_FRAC: begin
                ovf  = (sext != val);
                flag = ovf || v_in;
                res  = sext;
                if (flag && omc)
                    res = sext[WIDE-1] ? ~FMAX : FMAX;
            end
            MD_UINT: begin
                ovf  = |val[WIDE-1:ACC_W];
                flag = ovf || v_in;
                if (flag) begin
                    if (omc)
                        res = (val > UBIG) ? '0 : UMAX;
                    else
                        res = val & UMAX;
                end
            end
            default: begin
                res = val;
            end
        endcase
    end

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter int OP_W      = 32,
    parameter int ACC_W     = 48,
    parameter int KEEP_W    = 40,
    parameter int FRAC_SH   = 24,
    parameter int FORCE_BIT = 50,
    parameter int SINT_W    = 32,
    parameter int UBIG_BIT  = 53
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2:0]           in_op,
    input  logic [SEL_W-1:0]     in_dst,
    input  logic [SEL_W-1:0]     in_src,
    input  logic                 in_sat,
    input  logic [OP_W-1:0]      in_a,
    input  logic [OP_W-1:0]      in_b,
    output logic                 res_valid,
    output logic [2*OP_W-1:0]    res_prod,
    output logic [2*OP_W-1:0]    res_acc,
    output logic [SR_W-1:0]      status
);

    localparam int WIDE = 2 * OP_W;

    mac_state_e           state_q, state_d;
    mac_op_e              op_q;
    logic [SEL_W-1:0]     dst_q, src_q;
    logic                 sat_q;
    logic [OP_W-1:0]      a_q, b_q;
    logic [WIDE-1:0]      prod_q;
    mac_sr_t              sr_q;
    logic [WIDE-1:0]      acc_q [NACC];

    logic                 take;
    mac_mode_e            mode;
    logic [WIDE-1:0]      prod_new;
    logic                 prod_ovf;
    logic [WIDE-1:0]      acc_cur;
    logic [WIDE-1:0]      sat_res;
    logic                 sat_ovf;
    logic [WIDE-1:0]      acc_wd;
    logic [NACC-1:0]      acc_we;

    assign take = in_valid && (state_q == ST_IDLE);
    assign mode = mode_of(sr_q);

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    if (mac_op_e'(in_op) == OP_MAC)      state_d = ST_MUL;
                    else if (mac_op_e'(in_op) == OP_SAT) state_d = ST_SAT;
                    else                                 state_d = ST_XFER;
                end
            end
            ST_MUL:  state_d = ST_ACC;
            ST_ACC:  state_d = sat_q ? ST_SAT : ST_DONE;
            ST_SAT:  state_d = ST_DONE;
            ST_XFER: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        res_valid = (state_q == ST_DONE);
        res_prod  = prod_q;
        res_acc   = acc_q[dst_q];
        status    = sr_q;
    end

    // ---------------------------------------------------------------
    // Arithmetic helpers
    // ---------------------------------------------------------------
    mac_product #(
        .OP_W      (OP_W),
        .KEEP_W    (KEEP_W),
        .FRAC_SH   (FRAC_SH),
        .FORCE_BIT (FORCE_BIT)
    ) u_prod (
        .a    (a_q),
        .b    (b_q),
        .mode (mode),
        .omc  (sr_q.omc),
        .rt   (sr_q.rt),
        .prod (prod_new),
        .ovf  (prod_ovf)
    );

    assign acc_cur = acc_q[dst_q];

    mac_saturate #(
        .WIDE     (WIDE),
        .ACC_W    (ACC_W),
        .SINT_W   (SINT_W),
        .UBIG_BIT (UBIG_BIT)
    ) u_sat (
        .val  (acc_cur),
        .mode (mode),
        .omc  (sr_q.omc),
        .v_in (sr_q.v),
        .res  (sat_res),
        .ovf  (sat_ovf)
    );

    // ---------------------------------------------------------------
    // Command capture, product and status registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_MAC;
            dst_q  <= '0;
            src_q  <= '0;
            sat_q  <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
            prod_q <= '0;
            sr_q   <= '0;
        end else begin
            if (take) begin
                op_q  <= mac_op_e'(in_op);
                dst_q <= in_dst;
                src_q <= in_src;
                sat_q <= in_sat;
                a_q   <= in_a;
                b_q   <= in_b;
            end
            unique case (state_q)
                ST_MUL: begin
                    prod_q <= prod_new;
                    if (prod_ovf) sr_q.v <= 1'b1;
                end
                ST_SAT: begin
                    if (sat_ovf) sr_q.v <= 1'b1;
                    if (sat_ovf || sr_q.v) sr_q.pav[dst_q] <= 1'b1;
                end
                ST_XFER: begin
                    if (op_q == OP_MOVE)
                        sr_q.pav[dst_q] <= sr_q.pav[src_q];
                    else if (op_q == OP_WRSR)
                        sr_q <= mac_sr_t'(a_q[SR_W-1:0]);
                end
                default: ;
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Accumulator write path
    // ---------------------------------------------------------------
    always_comb begin
        acc_we = '0;
        acc_wd = acc_cur;
        unique case (state_q)
            ST_ACC: begin
                acc_we[dst_q] = 1'b1;
                acc_wd        = acc_cur + prod_q;
            end
            ST_SAT: begin
                acc_we[dst_q] = 1'b1;
                acc_wd        = sat_res;
            end
            ST_XFER: begin
                if (op_q == OP_MOVE) begin
                    acc_we[dst_q] = 1'b1;
                    acc_wd        = acc_q[src_q];
                end else if (op_q == OP_LOAD) begin
                    acc_we[dst_q] = 1'b1;
                    acc_wd        = {a_q, b_q};
                end
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < NACC; g++) begin : g_acc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        acc_q[g] <= '0;
            else if (acc_we[g]) acc_q[g] <= acc_wd;
        end
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    // R9: overflow flag only falls through a status write
    assert_v_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q.v && !(state_q == ST_XFER && op_q == OP_WRSR)) |=> sr_q.v);

    // R10: a taken command makes the block busy next cycle
    assert_busy_after_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R10: result strobe lasts one cycle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R2: unsigned product without saturate enable fits the 40-bit window
    assert_uint_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACC && mode == MD_UINT && !sr_q.omc)
            |-> (prod_q[WIDE-1:KEEP_W] == '0));

    // R5: signed clamp leaves a value inside the 32-bit signed range
    assert_sint_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && $past(state_q) == ST_SAT && mode == MD_SINT
         && sr_q.omc && sr_q.v)
            |-> (acc_q[dst_q][WIDE-1:SINT_W-1] == '0 || acc_q[dst_q][WIDE-1:SINT_W-1] == '1));

    // R5: a saturate with the overflow flag raised marks the accumulator
    assert_pav_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && $past(state_q) == ST_SAT && sr_q.v) |-> sr_q.pav[dst_q]);

    // R8: move leaves matching per-accumulator flags
    assert_move_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && op_q == OP_MOVE) |-> (sr_q.pav[dst_q] == sr_q.pav[src_q]));

endmodule

// File: tb/mac_sat_unit_test.sv
`timescale 1ns/1ps
module mac_sat_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = '0;
    logic [1:0]  in_dst = '0;
    logic [1:0]  in_src = '0;
    logic        in_sat = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        res_valid;
    logic [63:0] res_prod;
    logic [63:0] res_acc;
    logic [8:0]  status;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [63:0] m_acc [4];
    logic [8:0]  m_sr;
    logic [63:0] last_prod, last_acc;
    logic [8:0]  last_st;

    always #2.5 clk = ~clk;

    mac_sat_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_dst(in_dst), .in_src(in_src), .in_sat(in_sat),
        .in_a(in_a), .in_b(in_b), .res_valid(res_valid), .res_prod(res_prod),
        .res_acc(res_acc), .status(status)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // product model: {overflow, product}
    function automatic logic [64:0] model_prod(logic [31:0] a, logic [31:0] b, logic [8:0] sr);
        longint sa, sb, p, q;
        logic [63:0] u, rem;
        logic ov;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ov = 1'b0;
        if (sr[6]) begin
            p = sa * sb;
            q = p >>> 24;
            rem = 64'(p) & 64'hFFFFFF;
            if (sr[5]) begin
                if (rem > 64'h800000) q = q + 1;
                else if (rem == 64'h800000) q = q + (q & 1);
            end
            return {1'b0, 64'(q)};
        end else if (sr[7]) begin
            p = sa * sb;
            q = (p <<< 24) >>> 24;
            ov = (q != p);
            if (ov && sr[8]) p = (p < 0) ? ~(64'd1 << 50) : (64'd1 << 50);
            return {ov, 64'(p)};
        end else begin
            u = {32'd0, a} * {32'd0, b};
            ov = ((u >> 40) != 0);
            if (ov) u = sr[8] ? (64'd1 << 50) : (u & ((64'd1 << 40) - 1));
            return {ov, u};
        end
    endfunction

    // saturation model: {overflow, value}
    function automatic logic [64:0] model_sat(logic [63:0] v, logic [8:0] sr);
        longint s, r;
        logic ov;
        logic [63:0] u;
        s = longint'(v);
        if (sr[6] || sr[7]) begin
            r = (s <<< 16) >>> 16;
            ov = (r != s);
            if ((ov || sr[4]) && sr[8]) begin
                if (sr[6]) r = (r < 0) ? ~longint'(64'h7FFFFFFFFFFF) : longint'(64'h7FFFFFFFFFFF);
                else       r = (r < 0) ? longint'(64'hFFFFFFFF80000000) : longint'(64'h7FFFFFFF);
            end
            return {ov, 64'(r)};
        end else begin
            ov = ((v >> 48) != 0);
            u = v;
            if (ov || sr[4]) begin
                if (sr[8]) u = (v > (64'd1 << 53)) ? 64'd0 : ((64'd1 << 48) - 1);
                else       u = v & ((64'd1 << 48) - 1);
            end
            return {ov, u};
        end
    endfunction

    task automatic model_saturate(int d);
        logic [64:0] r;
        r = model_sat(m_acc[d], m_sr);
        if (r[64]) m_sr[4] = 1'b1;
        if (m_sr[4]) m_sr[d] = 1'b1;
        m_acc[d] = r[63:0];
    endtask

    task automatic do_cmd(string tag, logic [2:0] op, int d, int s, logic sat,
                          logic [31:0] a, logic [31:0] b);
        logic [64:0] pr;
        logic [63:0] exp_prod;
        exp_prod = 64'd0;
        case (op)
            3'd0: begin
                pr = model_prod(a, b, m_sr);
                if (pr[64]) m_sr[4] = 1'b1;
                exp_prod = pr[63:0];
                m_acc[d] = m_acc[d] + pr[63:0];
                if (sat) model_saturate(d);
            end
            3'd1: model_saturate(d);
            3'd2: begin
                m_acc[d] = m_acc[s];
                m_sr[d]  = m_sr[s];
            end
            3'd3: m_acc[d] = {a, b};
            3'd4: m_sr = a[8:0];
            default: ;
        endcase
        @(negedge clk);
        check({tag, " R10 idle ready"}, 64'(in_ready), 64'd1);
        in_valid = 1'b1; in_op = op; in_dst = 2'(d); in_src = 2'(s);
        in_sat = sat; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R10 busy"}, 64'(in_ready), 64'd0);
        while (!res_valid) @(negedge clk);
        last_prod = res_prod;
        last_acc  = res_acc;
        last_st   = status;
        check({tag, " acc"}, res_acc, m_acc[d]);
        check({tag, " status"}, 64'(status), 64'(m_sr));
        if (op == 3'd0) check({tag, " R4 prod"}, res_prod, exp_prod);
        @(negedge clk);
        check({tag, " R10 one-cycle strobe"}, 64'(res_valid), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_acc[i] = 64'd0;
        m_sr = 9'd0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R11 ready in reset", 64'(in_ready), 64'd1);
        check("R11 no strobe", 64'(res_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 status zero", 64'(status), 64'd0);
        check("R11 acc zero", res_acc, 64'd0);

        // R1 signed integer overflow with forced replacement
        do_cmd("R1 wr", 3'd4, 0, 0, 0, 32'h180, 0);
        do_cmd("R1 pos", 3'd0, 0, 0, 0, 32'h7FFFFFFF, 32'h7FFFFFFF);
        check("R1 forced pos", last_prod, 64'd1 << 50);
        check("R1 v set", 64'(last_st[4]), 64'd1);
        do_cmd("R1 neg", 3'd0, 1, 0, 0, 32'h80000000, 32'h7FFFFFFF);
        check("R1 forced neg", last_prod, ~(64'd1 << 50));

        // R2 unsigned integer
        do_cmd("R2 wr", 3'd4, 0, 0, 0, 32'h000, 0);
        do_cmd("R2 trunc", 3'd0, 2, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R2 low 40 bits", last_prod, 64'hFE00000001);
        do_cmd("R2 wr omc", 3'd4, 0, 0, 0, 32'h100, 0);
        do_cmd("R2 forced", 3'd0, 3, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R2 forced val", last_prod, 64'd1 << 50);

        // R3 fractional rounding
        do_cmd("R3 wr", 3'd4, 0, 0, 0, 32'h060, 0);
        do_cmd("R3 half even0", 3'd0, 0, 0, 0, 32'h800000, 32'd1);
        check("R3 half to even down", last_prod, 64'd0);
        do_cmd("R3 half odd", 3'd0, 0, 0, 0, 32'h800000, 32'd3);
        check("R3 half to even up", last_prod, 64'd2);
        do_cmd("R3 above half", 3'd0, 0, 0, 0, 32'h800001, 32'd1);
        check("R3 above half up", last_prod, 64'd1);
        do_cmd("R3 wr nort", 3'd4, 0, 0, 0, 32'h040, 0);
        do_cmd("R3 no round", 3'd0, 0, 0, 0, 32'h800000, 32'd3);
        check("R3 truncated", last_prod, 64'd1);

        // R5 signed saturation
        do_cmd("R5 wr", 3'd4, 0, 0, 0, 32'h180, 0);
        do_cmd("R12 load", 3'd3, 1, 0, 0, 32'h00008000, 32'h0);
        check("R12 loaded", last_acc, 64'h0000800000000000);
        do_cmd("R5 neg clamp", 3'd1, 1, 0, 0, 0, 0);
        check("R5 neg value", last_acc, 64'hFFFFFFFF80000000);
        check("R5 flag", 64'(last_st[1]), 64'd1);
        do_cmd("R12 load2", 3'd3, 1, 0, 0, 32'h00010000, 32'h5);
        do_cmd("R5 pos clamp", 3'd1, 1, 0, 0, 0, 0);
        check("R5 pos value", last_acc, 64'h7FFFFFFF);

        // R8 move copies flag
        do_cmd("R8 move set", 3'd2, 0, 1, 0, 0, 0);
        check("R8 flag copied", 64'(last_st[0]), 64'd1);
        do_cmd("R8 move clr", 3'd2, 1, 2, 0, 0, 0);
        check("R8 flag cleared", 64'(last_st[1]), 64'd0);

        // R6 unsigned saturation
        do_cmd("R6 wr", 3'd4, 0, 0, 0, 32'h100, 0);
        do_cmd("R6 load big", 3'd3, 2, 0, 0, 32'h00200000, 32'h1);
        do_cmd("R6 above", 3'd1, 2, 0, 0, 0, 0);
        check("R6 zero", last_acc, 64'd0);
        do_cmd("R6 load eq", 3'd3, 2, 0, 0, 32'h00200000, 32'h0);
        do_cmd("R6 equal", 3'd1, 2, 0, 0, 0, 0);
        check("R6 max48", last_acc, (64'd1 << 48) - 1);
        do_cmd("R6 wr nomc", 3'd4, 0, 0, 0, 32'h000, 0);
        do_cmd("R6 load tr", 3'd3, 2, 0, 0, 32'h00012345, 32'h6789ABCD);
        do_cmd("R6 trunc", 3'd1, 2, 0, 0, 0, 0);
        check("R6 truncated", last_acc, 64'h23456789ABCD);

        // R7 fractional saturation
        do_cmd("R7 wr", 3'd4, 0, 0, 0, 32'h140, 0);
        do_cmd("R7 load", 3'd3, 3, 0, 0, 32'hFFFE0000, 32'h0);
        do_cmd("R7 clamp", 3'd1, 3, 0, 0, 0, 0);
        check("R7 pos clamp", last_acc, 64'h7FFFFFFFFFFF);

        // R9 sticky then cleared
        check("R9 sticky", 64'(last_st[4]), 64'd1);
        do_cmd("R9 small mac", 3'd0, 0, 0, 0, 32'd2, 32'd3);
        check("R9 still set", 64'(last_st[4]), 64'd1);
        do_cmd("R9 clear", 3'd4, 0, 0, 0, 32'h000, 0);
        check("R9 cleared", 64'(last_st[4]), 64'd0);

        // R4 accumulate with other accumulators intact
        do_cmd("R4 load", 3'd3, 3, 0, 0, 32'h0, 32'd100);
        do_cmd("R4 mac", 3'd0, 3, 0, 0, 32'd7, 32'd6);
        check("R4 sum", last_acc, 64'd142);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int sel;
            logic [31:0] ra, rb;
            sel = $urandom_range(0, 99);
            ra = $urandom;
            rb = $urandom;
            if ($urandom_range(0, 3) == 0) ra = ra & 32'h00FFFFFF;
            if ($urandom_range(0, 3) == 0) rb = rb & 32'h0000FFFF;
            if (sel < 50)
                do_cmd("R4 rnd mac", 3'd0, $urandom_range(0, 3), 0, 1'($urandom_range(0, 1)), ra, rb);
            else if (sel < 62)
                do_cmd("R5 rnd sat", 3'd1, $urandom_range(0, 3), 0, 0, 0, 0);
            else if (sel < 72)
                do_cmd("R8 rnd move", 3'd2, $urandom_range(0, 3), $urandom_range(0, 3), 0, 0, 0);
            else if (sel < 84)
                do_cmd("R12 rnd load", 3'd3, $urandom_range(0, 3), 0, 0, ra, rb);
            else
                do_cmd("R9 rnd wr", 3'd4, 0, 0, 0, ra & 32'h1EF, 0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule